// File: doc/BRIEF.md
# Converter Parallel Read Port

This block models the digital bus side of a 12-bit successive-approximation converter. A host reaches it through active-low select and read strobes plus an active-high byte-select input. Each access turns on the data outputs. An access with the byte select low also starts a new conversion. The port then holds its active-low busy flag low while a conversion is in progress. When the conversion ends, it loads the new result into an output latch and raises the flag in the same clock.

The analog conversion is replaced by a timer that counts a fixed number of clock cycles and then captures a test sample word. The three-state bus is modelled as an output-enable plus a data vector that reads zero while it is disabled. A read always returns the latched result, so a read taken during a conversion returns the result of the conversion before it. A host that cannot stall can read the result of the previous start on the access that launches the next conversion. With the byte select high, the low eight lanes instead carry the upper four result bits, so an 8-bit host can fetch the word in two reads.

Top module: `adc_bus_port`

## Requirements
- R1: After reset the result latch holds zero, `busyN` is 1, `dataOe` is 0 and `dataOut` is zero.
- R2: `dataOe` is 1 exactly when `selN` and `rdN` are both 0; while `dataOe` is 0, `dataOut` is all zeros.
- R3: A conversion starts when the access strobe (`selN`=0 and `rdN`=0) is seen active at a clock edge after being inactive at the previous edge, with `hiByteSel`=0 and `busyN`=1. `busyN` is then 0 from the cycle after that edge.
- R4: `busyN` stays 0 for exactly CONV_CYCLES cycles. At the edge that ends the conversion, the latch loads `sampleIn` and `busyN` returns to 1.
- R5: A new strobe edge that arrives while `busyN` is 0 is ignored, and this includes the edge at which the conversion completes. A strobe edge in any later cycle starts a new conversion.
- R6: A strobe edge with `hiByteSel`=1 does not start a conversion.
- R7: With `hiByteSel`=0 and outputs enabled, `dataOut[11:0]` equals result bits 11..0, with bit 11 as the MSB.
- R8: With `hiByteSel`=1 and outputs enabled, `dataOut[11:8]` and `dataOut[3:0]` both carry result bits 11..8, and `dataOut[7:4]` is zero.
- R9: A read made while a conversion runs shows the result of the previous conversion.
- R10: Holding the strobe active after a conversion completes does not start another conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read |
| hiByteSel | input | 1 | 1 = byte lanes carry the upper result bits and the access starts no conversion |
| sampleIn | input | 12 | Word captured as the conversion result |
| busyN | output | 1 | Active-low conversion-in-progress flag |
| dataOe | output | 1 | Output drive enable |
| dataOut | output | 12 | Data lanes |

## Verification
The completion of a conversion and a new start request can fall on the same clock edge. At that edge `busyN` is still low, so the request must be dropped. The bench sweeps the delay of a second strobe edge after a start across every edge of the conversion and two edges beyond it. For each delay it counts the cycles with `busyN` low in a fixed window, expecting CONV_CYCLES cycles for any delay up to and including the completion edge and twice that afterwards.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic startConv;  // a conversion is accepted this cycle
    logic loadLatch;  // capture the sample word this cycle
  } ctrlStrobe_t;

  // Width of a down counter that must hold values up to n-1
  function automatic int cntWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int CONV_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accessAct,
  input  logic        hiByteSel,
  output logic        busyN,
  output ctrlStrobe_t strobes
);

  localparam int CW = cntWidth(CONV_CYCLES);
  localparam logic [CW-1:0] CNT_LOAD = CW'(CONV_CYCLES - 1);

  logic          accessQ;
  logic          busyQ;
  logic [CW-1:0] remain;
  logic          accessEdge;
  logic          startReq;

  // Start only on the inactive-to-active transition of the strobe
  assign accessEdge = accessAct & ~accessQ;
  assign startReq   = accessEdge & ~hiByteSel;

  always_comb begin
    strobes           = '0;
    strobes.startConv = startReq & ~busyQ;
    strobes.loadLatch = busyQ & (remain == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accessQ <= 1'b0;
      busyQ   <= 1'b0;
      remain  <= '0;
    end else begin
      accessQ <= accessAct;
      if (strobes.startConv) begin
        busyQ  <= 1'b1;
        remain <= CNT_LOAD;
      end else if (strobes.loadLatch) begin
        busyQ  <= 1'b0;
      end else if (busyQ) begin
        remain <= remain - 1'b1;
      end
    end
  end

  assign busyN = ~busyQ;

endmodule

// File: rtl/adc_bus_dp.sv
module adc_bus_dp
  import adc_bus_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              hiByteSel,
  input  logic              outEn,
  output logic [DATA_W-1:0] dataOut
);

  localparam int HI_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] resultQ;
  logic [DATA_W-1:0] laneVal;
  logic              startSeen;

  assign startSeen = strobes.startConv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (strobes.loadLatch && !startSeen) begin
      resultQ <= sampleIn;
    end
  end

  // Per-lane multiplexer
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    if (g >= BYTE_W) begin : g_top
      assign laneVal[g] = resultQ[g];
    end else if (g < HI_W) begin : g_fold
      assign laneVal[g] = hiByteSel ? resultQ[BYTE_W + g] : resultQ[g];
    end else begin : g_zero
      assign laneVal[g] = hiByteSel ? 1'b0 : resultQ[g];
    end
  end

  assign dataOut = outEn ? laneVal : '0;

endmodule

// File: rtl/adc_bus_port.sv
module adc_bus_port
  import adc_bus_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int CONV_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              rdN,
  input  logic              hiByteSel,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              busyN,
  output logic              dataOe,
  output logic [DATA_W-1:0] dataOut
);

  ctrlStrobe_t strobes;
  logic        accessAct;

  assign accessAct = ~selN & ~rdN;
  assign dataOe    = accessAct;

  adc_bus_ctrl #(
    .CONV_CYCLES(CONV_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accessAct(accessAct),
    .hiByteSel(hiByteSel),
    .busyN    (busyN),
    .strobes  (strobes)
  );

  adc_bus_dp #(
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .sampleIn (sampleIn),
    .hiByteSel(hiByteSel),
    .outEn    (accessAct),
    .dataOut  (dataOut)
  );

endmodule

// File: rtl/adc_bus_port_chk.sv
module adc_bus_port_chk #(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int CONV_CYCLES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              selN,
  input logic              rdN,
  input logic              hiByteSel,
  input logic [DATA_W-1:0] sampleIn,
  input logic              busyN,
  input logic              dataOe,
  input logic [DATA_W-1:0] dataOut
);

  localparam int HI_W = DATA_W - BYTE_W;

  logic   strobeNow;
  logic   strobePrev;
  int     lowRun;

  assign strobeNow = ~selN & ~rdN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobePrev <= 1'b0;
      lowRun     <= 0;
    end else begin
      strobePrev <= strobeNow;
      lowRun     <= busyN ? 0 : lowRun + 1;
    end
  end

  // R2: enable follows the decoded access and a disabled bus reads zero
  always_comb begin
    assert_oe_decode_R2: assert (!rstN || (dataOe == strobeNow));
    assert_idle_zero_R2: assert (!rstN || dataOe || (dataOut == '0));
  end

  // R3: an accepted edge drops busy next cycle
  assert_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobeNow && !strobePrev && !hiByteSel && busyN) |=> !busyN);

  // R4: busy low never outlasts the conversion time and ends exactly on it
  assert_busy_max_R4: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= CONV_CYCLES);
  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyN) |-> (lowRun == CONV_CYCLES));

  // R4/R7: the word on the bus at completion is the captured sample
  assert_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busyN) && dataOe && !hiByteSel) |-> (dataOut == $past(sampleIn)));

  // R6: upper-byte access never starts a conversion
  assert_hi_nostart_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobeNow && !strobePrev && hiByteSel && busyN) |=> busyN);

  // R8: byte-lane arrangement with the upper byte selected
  assert_hi_lanes_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && hiByteSel) |->
      ((dataOut[BYTE_W-1:HI_W] == '0) &&
       (dataOut[HI_W-1:0] == dataOut[DATA_W-1:BYTE_W])));

  // R9: the bus holds the old result throughout a conversion
  assert_hold_old_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && $past(!busyN) && dataOe && $past(dataOe) && $stable(hiByteSel))
      |-> $stable(dataOut));

endmodule

bind adc_bus_port adc_bus_port_chk #(
  .DATA_W     (DATA_W),
  .BYTE_W     (BYTE_W),
  .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .selN     (selN),
  .rdN      (rdN),
  .hiByteSel(hiByteSel),
  .sampleIn (sampleIn),
  .busyN    (busyN),
  .dataOe   (dataOe),
  .dataOut  (dataOut)
);

// File: tb/adc_bus_port_tb.sv
module adc_bus_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 6;

  logic        clk = 1'b0;
  logic        rstN;
  logic        selN;
  logic        rdN;
  logic        hiByteSel;
  logic [11:0] sampleIn;
  logic        busyN;
  logic        dataOe;
  logic [11:0] dataOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_bus_port #(.DATA_W(12), .BYTE_W(8), .CONV_CYCLES(N)) u_dut (
    .clk(clk), .rstN(rstN), .selN(selN), .rdN(rdN), .hiByteSel(hiByteSel),
    .sampleIn(sampleIn), .busyN(busyN), .dataOe(dataOe), .dataOut(dataOut)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] hiView(input logic [11:0] v);
    return {v[11:8], 4'b0000, v[11:8]};
  endfunction

  // One full conversion with the strobe held low, then an upper-byte read
  task automatic runConv(input logic [11:0] smp, input logic [11:0] prev);
    sampleIn = smp; hiByteSel = 1'b0; selN = 1'b0; rdN = 1'b0;
    #1;
    check("R2 oe on", dataOe, 1);
    check("R9 old word before start", dataOut, prev);
    tick();
    check("R3 busy low after start", busyN, 0);
    check("R9 old word during conversion", dataOut, prev);
    for (int i = 1; i < N; i++) begin
      tick();
      check("R4 busy held low", busyN, 0);
    end
    tick();
    check("R4 busy high at end", busyN, 1);
    check("R7 full word", dataOut, smp);
    tick();
    tick();
    check("R10 held strobe no restart", busyN, 1);
    selN = 1'b1; rdN = 1'b1;
    #1;
    check("R2 oe off", dataOe, 0);
    check("R2 bus zero when off", dataOut, 0);
    tick();
    hiByteSel = 1'b1; selN = 1'b0; rdN = 1'b0;
    #1;
    check("R8 upper byte lanes", dataOut, hiView(smp));
    tick();
    check("R6 upper read no start", busyN, 1);
    tick();
    selN = 1'b1; rdN = 1'b1; hiByteSel = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] prev;
    logic [11:0] smp;
    rstN = 1'b0; selN = 1'b1; rdN = 1'b1; hiByteSel = 1'b0; sampleIn = '0;
    tick();
    tick();
    check("R1 busy idle in reset", busyN, 1);
    check("R1 oe off in reset", dataOe, 0);
    check("R1 bus zero in reset", dataOut, 0);
    rstN = 1'b1;
    tick();
    // Latch contents after reset, read without starting
    hiByteSel = 1'b0; selN = 1'b0; rdN = 1'b1;
    #1;
    check("R2 read alone no oe", dataOe, 0);
    selN = 1'b1; rdN = 1'b0;
    #1;
    check("R2 select alone no oe", dataOe, 0);
    hiByteSel = 1'b1; selN = 1'b0;
    #1;
    check("R1 latch zero", dataOut, 0);
    tick();
    check("R6 no start on upper read", busyN, 1);
    selN = 1'b1; rdN = 1'b1; hiByteSel = 1'b0;
    tick();

    // Sweep of sample words
    prev = '0;
    for (int s = 0; s < 24; s++) begin
      smp = 12'((s * 12'h9E3 + 12'h15A) ^ (s << 7));
      if (s == 22) smp = 12'hFFF;
      if (s == 23) smp = 12'h000;
      runConv(smp, prev);
      prev = smp;
    end

    // Second strobe edge k edges after the start edge
    for (int k = 2; k <= N + 2; k++) begin
      int lowCnt;
      int expLow;
      lowCnt = 0;
      sampleIn = 12'(12'h3C5 + k);
      selN = 1'b0; rdN = 1'b0; hiByteSel = 1'b0;
      tick();
      if (!busyN) lowCnt++;
      rdN = 1'b1;
      for (int t = 1; t <= 3 * N + 4; t++) begin
        if (t == k) rdN = 1'b0;
        if (t == k + 1) rdN = 1'b1;
        tick();
        if (!busyN) lowCnt++;
      end
      expLow = (k <= N) ? N : 2 * N;
      check("R5 busy cycles vs second edge", lowCnt, expLow);
      selN = 1'b1; rdN = 1'b1;
      tick();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule